// File: doc/BRIEF.md
# UART Channel FIFO Controller

This block holds the transmit and receive byte queues of one serial channel and manages them through a write-only FIFO control byte on a simple host bus. The serializer pops bytes from the transmit queue and the host pushes bytes into it. The deserializer pushes bytes into the receive queue and the host pops them. Both queues are first-word-fall-through: the byte at the head is always visible on the data output.

The block reports the fill level, the empty flag and the full flag of each queue. It also raises a receive trigger request that is compared against a programmable threshold, and it keeps a sticky receive overrun flag. It drives the two status bits that an interrupt identification register shows for FIFO mode.

With the enable bit low, the channel works in single-byte holding mode and each queue holds one byte. Any change of mode empties both queues. Clear commands are single-cycle actions and are never stored.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, both full flags are 0, rx_trig and rx_overrun are 0, and fifo_mode is 2'b00.
- R2: While FIFO mode is on, each queue holds up to 16 bytes and returns them in push order. The level counts the stored bytes and full is 1 at 16. A push into a full queue is dropped.
- R3: A control write with bit 0 = 0 empties both queues and leaves single-byte holding mode selected.
- R4: A control write with bit 0 = 1 while FIFO mode is off turns FIFO mode on and empties both queues.
- R5: A control write with bits 0 and 1 both set empties the receive queue and clears rx_overrun, and leaves the transmit queue intact. In the cycle of such a clear, a receive push or pop has no effect.
- R6: A control write with bits 0 and 2 both set empties the transmit queue and leaves the receive queue intact. In the cycle of such a clear, a transmit push or pop has no effect.
- R7: Bits 7:6 of a control write with bit 0 set select the receive threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. rx_trig is 1 exactly while the receive level is at or above the threshold.
- R8: While FIFO mode is off, each queue holds at most one byte, full is 1 when that byte is present, and the receive threshold is 1.
- R9: A receive push that is dropped because the queue is full sets rx_overrun. The flag stays 1 until reset, a receive clear or a mode flush.
- R10: fifo_mode reads 2'b11 while FIFO mode is on and 2'b00 otherwise.
- R11: The head byte is shown on the data output while the queue is not empty. A pop on an empty queue is ignored. A push and a pop in the same cycle on a full queue both take effect.
- R12: Bit 3 and bits 5:4 of a control write are accepted but change no queue contents, level, flag or threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the FIFO control byte |
| cfg_wdata | input | 8 | Control byte written |
| tx_push | input | 1 | Host pushes a byte into the transmit queue |
| tx_din | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Serializer takes the head transmit byte |
| tx_dout | output | 8 | Head byte of the transmit queue |
| tx_level | output | 5 | Number of bytes in the transmit queue |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_full | output | 1 | Transmit queue is at its current capacity |
| rx_push | input | 1 | Deserializer pushes a received byte |
| rx_din | input | 8 | Received byte to push |
| rx_pop | input | 1 | Host takes the head receive byte |
| rx_dout | output | 8 | Head byte of the receive queue |
| rx_level | output | 5 | Number of bytes in the receive queue |
| rx_empty | output | 1 | Receive queue is empty |
| rx_full | output | 1 | Receive queue is at its current capacity |
| rx_overrun | output | 1 | Sticky flag: a receive byte was dropped |
| rx_trig | output | 1 | Receive level is at or above the threshold |
| fifo_mode | output | 2 | FIFO-mode status bits for interrupt identification |

## Verification
The hardest cases to reach from the ports are those where a clear or mode flush lands in the same cycle as a push or pop on a full queue, and where a threshold change arrives while the level sits exactly at a threshold. Directed sequences fill both queues to capacity, then issue push-with-pop and overflow pushes. They step the receive level through each of the four thresholds one byte at a time. A long random phase follows. It keeps both queues near full through biased push and pop rates and mixes in rare control writes with random clear, reserved and threshold bits, so that these collisions occur many times.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        RXT_ONE      = 2'b00,
        RXT_QUARTER  = 2'b01,
        RXT_HALF     = 2'b10,
        RXT_NEARFULL = 2'b11
    } rx_thr_e;

    typedef struct packed {
        logic    en;
        logic    dma;
        rx_thr_e thr;
    } fifo_cfg_t;

    function automatic logic [7:0] thr_bytes(input rx_thr_e sel);
        case (sel)
            RXT_ONE:      thr_bytes = 8'd1;
            RXT_QUARTER:  thr_bytes = 8'd4;
            RXT_HALF:     thr_bytes = 8'd8;
            default:      thr_bytes = 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/fifo_cfg_reg.sv
module fifo_cfg_reg
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        wdata,
    output fifo_cfg_t         cfg,
    output logic              flush_rx,
    output logic              flush_tx
);

    fifo_cfg_t cfg_d, cfg_q;
    logic      mode_flush;

    always_comb begin
        cfg_d      = cfg_q;
        mode_flush = we && (!wdata[0] || !cfg_q.en);
        flush_rx   = mode_flush || (we && wdata[0] && wdata[1]);
        flush_tx   = mode_flush || (we && wdata[0] && wdata[2]);
        if (we) begin
            cfg_d.en = wdata[0];
            if (wdata[0]) begin
                cfg_d.dma = wdata[3];
                cfg_d.thr = rx_thr_e'(wdata[7:6]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          drop
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t  st_d, st_q;
    logic pop_ok, push_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        full    = single ? (st_q.cnt != '0) : (st_q.cnt == CW'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        push_ok = push && (!full || pop_ok);
        drop    = push && !push_ok && !clr;
        if (clr) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr           = nxt(st_q.wr);
            end
            if (pop_ok) st_d.rd = nxt(st_q.rd);
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);

endmodule

// File: rtl/rx_thr_cmp.sv
module rx_thr_cmp
    import uart_fifo_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic          fifo_on,
    input  rx_thr_e       sel,
    input  logic [CW-1:0] count,
    output logic          hit
);

    logic [7:0] lvl;

    always_comb begin
        lvl = fifo_on ? thr_bytes(sel) : 8'd1;
        hit = (8'(count) >= lvl);
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_din,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_dout,
    output logic [CW-1:0]     tx_level,
    output logic              tx_empty,
    output logic              tx_full,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_din,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_dout,
    output logic [CW-1:0]     rx_level,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_trig,
    output logic [1:0]        fifo_mode
);

    typedef struct packed {
        logic ovr;
    } sticky_t;

    fifo_cfg_t cfg;
    logic      flush_rx, flush_tx;
    logic      rx_drop, tx_drop;
    sticky_t   stk_d, stk_q;

    fifo_cfg_reg i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .flush_rx (flush_rx),
        .flush_tx (flush_tx)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flush_tx),
        .single (!cfg.en),
        .push   (tx_push),
        .din    (tx_din),
        .pop    (tx_pop),
        .dout   (tx_dout),
        .count  (tx_level),
        .empty  (tx_empty),
        .full   (tx_full),
        .drop   (tx_drop)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_rxq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flush_rx),
        .single (!cfg.en),
        .push   (rx_push),
        .din    (rx_din),
        .pop    (rx_pop),
        .dout   (rx_dout),
        .count  (rx_level),
        .empty  (rx_empty),
        .full   (rx_full),
        .drop   (rx_drop)
    );

    rx_thr_cmp #(.CW(CW)) i_thr (
        .fifo_on (cfg.en),
        .sel     (cfg.thr),
        .count   (rx_level),
        .hit     (rx_trig)
    );

    always_comb begin
        stk_d = stk_q;
        if (flush_rx)     stk_d.ovr = 1'b0;
        else if (rx_drop) stk_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign rx_overrun = stk_q.ovr;
    assign fifo_mode  = {2{cfg.en}};

endmodule

// File: rtl/uart_fifo_chk.sv
module uart_fifo_chk #(
    parameter int unsigned CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_wdata,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [CW-1:0] rx_level,
    input logic [CW-1:0] tx_level,
    input logic          rx_empty,
    input logic          tx_empty,
    input logic          rx_full,
    input logic          rx_overrun,
    input logic          rx_trig,
    input logic [1:0]    fifo_mode
);

    // R3
    off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_wdata[0] |=> rx_empty && tx_empty && fifo_mode == 2'b00);

    // R10
    mode_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[0] |=> fifo_mode == 2'b11);

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && rx_push && !rx_pop && !cfg_we |=> rx_overrun);

    // R8
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode == 2'b00 |-> rx_level <= CW'(1) && tx_level <= CW'(1));

    // R7
    empty_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !rx_trig);

    // R2
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we && !rx_push && !rx_pop |=> $stable(rx_level));

endmodule

bind uart_fifo_ctl uart_fifo_chk #(.CW(CW)) i_chk (.*);

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic       tx_push, tx_pop, rx_push, rx_pop;
    logic [7:0] tx_din, rx_din, tx_dout, rx_dout;
    logic [4:0] tx_level, rx_level;
    logic       tx_empty, tx_full, rx_empty, rx_full, rx_overrun, rx_trig;
    logic [1:0] fifo_mode;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    logic [7:0] m_tx[$];
    logic [7:0] m_rx[$];
    logic       m_en  = 0;
    logic [1:0] m_sel = 0;
    logic       m_ovr = 0;

    always #4 clk = ~clk;

    uart_fifo_ctl i_uart_fifo_ctl (.*);

    function automatic int thr_of(input logic en, input logic [1:0] s);
        if (!en) return 1;
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string ctx, input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, ctx, act, exp);
        end
    endtask

    task automatic compare(input string ctx);
        int cap;
        cap = m_en ? 16 : 1;
        chk(ctx, "R2 rx_level", int'(rx_level), m_rx.size());
        chk(ctx, "R2 tx_level", int'(tx_level), m_tx.size());
        chk(ctx, "R2 rx_empty", int'(rx_empty), int'(m_rx.size() == 0));
        chk(ctx, "R2 tx_empty", int'(tx_empty), int'(m_tx.size() == 0));
        chk(ctx, "R8 rx_full",  int'(rx_full),  int'(m_rx.size() == cap));
        chk(ctx, "R8 tx_full",  int'(tx_full),  int'(m_tx.size() == cap));
        if (m_rx.size() != 0) chk(ctx, "R11 rx_dout", int'(rx_dout), int'(m_rx[0]));
        if (m_tx.size() != 0) chk(ctx, "R11 tx_dout", int'(tx_dout), int'(m_tx[0]));
        chk(ctx, "R7 rx_trig", int'(rx_trig), int'(m_rx.size() >= thr_of(m_en, m_sel)));
        chk(ctx, "R9 rx_overrun", int'(rx_overrun), int'(m_ovr));
        chk(ctx, "R10 fifo_mode", int'(fifo_mode), m_en ? 3 : 0);
    endtask

    task automatic model_q(inout logic [7:0] q[$], input logic clr, input int cap,
                           input logic push, input logic [7:0] d, input logic pop,
                           output logic dropped);
        logic pop_ok, push_ok;
        dropped = 0;
        if (clr) begin
            q.delete();
            return;
        end
        pop_ok  = pop && q.size() != 0;
        push_ok = push && (q.size() < cap || pop_ok);
        dropped = push && !push_ok;
        if (pop_ok) void'(q.pop_front());
        if (push_ok) q.push_back(d);
    endtask

    task automatic step(input string ctx, input logic we, input logic [7:0] wd,
                        input logic tp, input logic [7:0] td, input logic tpo,
                        input logic rp, input logic [7:0] rd, input logic rpo);
        logic flush, crx, ctx_, drx, dtx;
        int   cap;
        cfg_we = we; cfg_wdata = wd;
        tx_push = tp; tx_din = td; tx_pop = tpo;
        rx_push = rp; rx_din = rd; rx_pop = rpo;
        @(posedge clk);
        flush = we && (!wd[0] || !m_en);
        crx   = flush || (we && wd[0] && wd[1]);
        ctx_  = flush || (we && wd[0] && wd[2]);
        cap   = m_en ? 16 : 1;
        model_q(m_tx, ctx_, cap, tp, td, tpo, dtx);
        model_q(m_rx, crx, cap, rp, rd, rpo, drx);
        if (crx) m_ovr = 0;
        else if (drx) m_ovr = 1;
        if (we) begin
            m_en = wd[0];
            if (wd[0]) m_sel = wd[7:6];
        end
        #2;
        cfg_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        compare(ctx);
    endtask

    task automatic wr(input string ctx, input logic [7:0] v);
        step(ctx, 1, v, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        rst_n = 0; cfg_we = 0; cfg_wdata = 0;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; tx_din = 0; rx_din = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        compare("R1 reset");
        rst_n = 1;

        // R8 single-byte mode, R9 overrun when the one slot is taken
        step("R8 push1", 0, 0, 1, 8'hA1, 0, 1, 8'h51, 0);
        step("R8 push2", 0, 0, 1, 8'hA2, 0, 1, 8'h52, 0);
        step("R11 push+pop full", 0, 0, 1, 8'hA3, 1, 1, 8'h53, 1);

        // R4 enable flushes
        wr("R4 enable", 8'h01);

        // R2 fill both to 16 and beyond
        for (int i = 0; i < 18; i++)
            step("R2 fill", 0, 0, 1, 8'(i + 8'h10), 0, 1, 8'(i + 8'h80), 0);
        step("R11 full push+pop", 0, 0, 1, 8'hEE, 1, 1, 8'hDD, 1);
        // R12: reserved and DMA bits keep contents
        wr("R12 bits5:4,3", 8'h39);
        // R5 receive clear with a colliding push
        step("R5 rx clear", 1, 8'h03, 0, 0, 0, 1, 8'h77, 0);
        // R6 transmit clear with colliding pop
        step("R6 tx clear", 1, 8'h05, 0, 0, 1, 0, 0, 0);
        step("R6 after", 0, 0, 1, 8'h42, 0, 1, 8'h24, 0);
        // R11 pop on empty
        step("R11 pop empty", 0, 0, 1, 8'h43, 1, 0, 0, 1);
        step("R11 pop empty2", 0, 0, 0, 0, 0, 0, 0, 1);
        step("R11 pop empty3", 0, 0, 0, 0, 0, 0, 0, 1);
        // R3 disable flushes
        wr("R3 disable", 8'hC6);

        // R7 each threshold code
        for (int s = 0; s < 4; s++) begin
            wr("R7 select", {2'(s), 6'b000001});
            wr("R7 rx clear", {2'(s), 6'b000011});
            for (int k = 0; k < 16; k++)
                step("R7 step", 0, 0, 0, 0, 0, 1, 8'(k), 0);
            for (int k = 0; k < 16; k++)
                step("R7 drain", 0, 0, 0, 0, 0, 0, 0, 1);
        end

        // random phase
        for (int n = 0; n < 6000; n++) begin
            logic we;
            logic [7:0] wd;
            we = ($urandom_range(0, 59) == 0);
            wd = 8'($urandom());
            if ($urandom_range(0, 7) != 0) wd[0] = 1'b1;
            if ($urandom_range(0, 3) != 0) wd[2:1] = 2'b00;
            step("random", we, wd,
                 $urandom_range(0, 9) < 6, 8'($urandom()), $urandom_range(0, 9) < 4,
                 $urandom_range(0, 9) < 6, 8'($urandom()), $urandom_range(0, 9) < 4);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule